// File: doc/BRIEF.md
# Transmit Packet Buffer Framer

The framer takes one outgoing frame as a byte stream and lays it out as a sequence of 16-bit word writes into a packet buffer, starting at byte offset 0 and stepping the write pointer by two for every word. A host strobes `start_i` together with the frame length. The framer then writes a header, the payload and a trailing control word, and pulses `done_o` so that the host knows it may queue the buffer for transmission.

The header has two words. The first is a status word that is cleared to zero. The second is a byte count equal to the padded frame length plus 6 bytes of overhead. Frames shorter than 60 bytes are padded with zero bytes, and the framer takes only the real bytes from the stream. An odd final byte is carried in the control word together with an odd-length flag. A length too large for the buffer is refused with a one-cycle error pulse, and nothing is written.

Top module: `txbuf_framer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_en_o`, `done_o`, `err_o` and `byte_ready_o` are all 0.
- R2: The first word of every accepted frame is written at byte offset 0 with value 0x0000.
- R3: The second word is written at offset 2 and holds max(len, 60) + 6.
- R4: Payload words follow from offset 4, with the offset rising by 2 per word. Each word holds the earlier byte in bits 7:0 and the later byte in bits 15:8.
- R5: A frame shorter than 60 bytes is padded with zero bytes up to 60. Exactly `len` bytes are taken from the stream, one on each cycle where `byte_valid_i` and `byte_ready_o` are both high.
- R6: When the padded length is odd, the last word holds the final byte in bits 7:0, bit 13 set (0x2000), and all other bits 0.
- R7: When the padded length is even, the last word is 0x0000.
- R8: A start with len > 2042 gives `err_o` high for exactly the next cycle. It takes no bytes and writes no words.
- R9: `done_o` is high for one cycle, in the cycle right after the control word appears on the write port.
- R10: A start strobe that arrives while a frame is in progress is ignored. It produces no error and does not disturb the frame.
- R11: Cycles without `byte_valid_i` stall the payload. The words written do not depend on where the gaps fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame (sampled when idle) |
| len_i | input | 12 | Frame length in bytes |
| byte_valid_i | input | 1 | Stream byte present |
| byte_data_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Framer takes the stream byte this cycle |
| wr_en_o | output | 1 | Buffer word write strobe |
| wr_addr_o | output | 11 | Byte offset of the word written |
| wr_data_o | output | 16 | Word written |
| done_o | output | 1 | Frame fully written |
| err_o | output | 1 | Length refused |

## Verification
The bench uses the default parameters: a 60-byte minimum, a 2042-byte maximum and 6 bytes of overhead. These values let it reach both the padding boundary (59, 60 and 61 bytes) and the refusal boundary (2042 is accepted and 2043 is refused) inside the run. Zero-length, single-byte and full-size frames cover the paths where the frame is all padding, has one real byte, or fills the whole buffer. Three patterns of stream gaps make the payload stall at both even and odd byte positions.

// File: rtl/txf_pkg.sv
package txf_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_STAT,
        S_CNT,
        S_DATA,
        S_CTRL,
        S_FIN
    } txf_state_e;

    localparam logic [15:0] ODD_FLAG = 16'h2000;
endpackage

// File: rtl/txf_len_plan.sv
module txf_len_plan #(
    parameter int LEN_W    = 12,
    parameter int MIN_LEN  = 60,
    parameter int MAX_LEN  = 2042,
    parameter int OVERHEAD = 6
) (
    input  logic [LEN_W-1:0] len_i,
    output logic [LEN_W-1:0] padded_o,
    output logic [15:0]      count_o,
    output logic             reject_o
);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

    always_comb begin
        padded_o = (len_i < MIN_L) ? MIN_L : len_i;
        count_o  = 16'(padded_o) + 16'(OVERHEAD);
        reject_o = (len_i > MAX_L);
    end
endmodule

// File: rtl/txf_ptr.sv
module txf_ptr #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr_o
);
    logic [ADDR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr)       ptr_d = '0;
        else if (step) ptr_d = ptr_q + ADDR_W'(2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    // R4: auto-increment by one word
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (ptr_o == $past(ptr_o) + ADDR_W'(2)));
endmodule

// File: rtl/txbuf_framer.sv
module txbuf_framer
    import txf_pkg::*;
#(
    parameter int LEN_W    = 12,
    parameter int MIN_LEN  = 60,
    parameter int MAX_LEN  = 2042,
    parameter int OVERHEAD = 6,
    parameter int ADDR_W   = $clog2(MAX_LEN + OVERHEAD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_data_i,
    output logic              byte_ready_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [15:0]       wr_data_o,
    output logic              done_o,
    output logic              err_o
);
    typedef struct packed {
        txf_state_e        state;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  padded;
        logic [15:0]       count;
        logic [LEN_W-1:0]  cnt;
        logic [7:0]        lo;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [15:0]       wr_data;
        logic              done;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    logic [LEN_W-1:0]  plan_padded;
    logic [15:0]       plan_count;
    logic              plan_reject;
    logic [ADDR_W-1:0] ptr;
    logic              ptr_clr, ptr_step;
    logic              from_stream;
    logic [LEN_W-1:0]  pairs_end;

    txf_len_plan #(
        .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .OVERHEAD(OVERHEAD)
    ) u_plan (
        .len_i(len_i), .padded_o(plan_padded), .count_o(plan_count), .reject_o(plan_reject)
    );

    txf_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .step(ptr_step), .ptr_o(ptr)
    );

    assign from_stream  = (r_q.cnt < r_q.len);
    assign pairs_end    = {r_q.padded[LEN_W-1:1], 1'b0};
    assign byte_ready_o = ((r_q.state == S_DATA) && from_stream) ||
                          ((r_q.state == S_CTRL) && r_q.padded[0]);

    always_comb begin
        logic       take;
        logic [7:0] bval;
        r_d      = r_q;
        r_d.wr_en = 1'b0;
        r_d.done  = 1'b0;
        r_d.err   = 1'b0;
        ptr_clr   = 1'b0;
        ptr_step  = 1'b0;
        take      = 1'b0;
        bval      = 8'h00;
        case (r_q.state)
            S_IDLE: begin
                if (start_i) begin
                    if (plan_reject) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.len    = len_i;
                        r_d.padded = plan_padded;
                        r_d.count  = plan_count;
                        r_d.cnt    = '0;
                        r_d.state  = S_STAT;
                        ptr_clr    = 1'b1;
                    end
                end
            end
            S_STAT: begin
                r_d.wr_en   = 1'b1;
                r_d.wr_addr = ptr;
                r_d.wr_data = 16'h0000;
                ptr_step    = 1'b1;
                r_d.state   = S_CNT;
            end
            S_CNT: begin
                r_d.wr_en   = 1'b1;
                r_d.wr_addr = ptr;
                r_d.wr_data = r_q.count;
                ptr_step    = 1'b1;
                r_d.state   = S_DATA;
            end
            S_DATA: begin
                take = from_stream ? byte_valid_i : 1'b1;
                bval = from_stream ? byte_data_i : 8'h00;
                if (take) begin
                    if (!r_q.cnt[0]) begin
                        r_d.lo = bval;
                    end else begin
                        r_d.wr_en   = 1'b1;
                        r_d.wr_addr = ptr;
                        r_d.wr_data = {bval, r_q.lo};
                        ptr_step    = 1'b1;
                    end
                    r_d.cnt = r_q.cnt + LEN_W'(1);
                    if (r_d.cnt == pairs_end) r_d.state = S_CTRL;
                end
            end
            S_CTRL: begin
                if (!r_q.padded[0]) begin
                    r_d.wr_en   = 1'b1;
                    r_d.wr_addr = ptr;
                    r_d.wr_data = 16'h0000;
                    ptr_step    = 1'b1;
                    r_d.state   = S_FIN;
                end else if (byte_valid_i) begin
                    r_d.wr_en   = 1'b1;
                    r_d.wr_addr = ptr;
                    r_d.wr_data = ODD_FLAG | {8'h00, byte_data_i};
                    ptr_step    = 1'b1;
                    r_d.state   = S_FIN;
                end
            end
            S_FIN: begin
                r_d.done  = 1'b1;
                r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_en_o   = r_q.wr_en;
    assign wr_addr_o = r_q.wr_addr;
    assign wr_data_o = r_q.wr_data;
    assign done_o    = r_q.done;
    assign err_o     = r_q.err;

    // R2: header status word at offset zero is cleared
    p_status_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_addr_o == '0) |-> (wr_data_o == 16'h0000));
    // R9: completion follows a buffer write
    p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_en_o));
    // R6, R7: control word carries only the low byte and the odd flag
    p_ctrl_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (($past(wr_data_o) & ~(ODD_FLAG | 16'h00FF)) == 16'h0000));
    // R8: refusal writes nothing and is a single pulse
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!wr_en_o && !err_o));
    // R5: stream is only drawn while a frame is in progress
    p_ready_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (!done_o && !err_o));
endmodule

// File: tb/txbuf_framer_bench.sv
module txbuf_framer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;
    // {len[11:0], gap[1:0]}
    localparam logic [13:0] VECS [NV] = '{
        {12'd0, 2'd0}, {12'd1, 2'd1}, {12'd59, 2'd0}, {12'd60, 2'd2},
        {12'd61, 2'd0}, {12'd61, 2'd1}, {12'd64, 2'd2}, {12'd101, 2'd2},
        {12'd2041, 2'd0}, {12'd2042, 2'd1}, {12'd250, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [11:0] len_i = '0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_data_i = '0;
    logic        byte_ready_o, wr_en_o, done_o, err_o;
    logic [10:0] wr_addr_o;
    logic [15:0] wr_data_o;

    txbuf_framer u_txbuf_framer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .byte_ready_o(byte_ready_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .done_o(done_o), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_err = 0;
    logic [15:0] exp_w [0:1099];
    int nwords = 0;
    int widx = 0;
    bit last_wr = 1'b0;
    bit mon_en = 1'b0;
    bit err_seen = 1'b0;
    int total_cyc = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'(i * 13 + seed + 1);
    endfunction

    always @(negedge clk) begin
        if (mon_en) begin
            if (err_o) err_seen = 1'b1;
            if (wr_en_o) begin
                string req;
                if (widx == 0) req = "R2";
                else if (widx == 1) req = "R3";
                else if (widx == nwords - 1) req = exp_w[widx][13] ? "R6" : "R7";
                else req = "R4/R5";
                if (widx < nwords) begin
                    check(wr_addr_o == 11'(2 * widx), {req, " addr"}, int'(wr_addr_o), 2 * widx);
                    check(wr_data_o == exp_w[widx], {req, " data"}, int'(wr_data_o), int'(exp_w[widx]));
                end else begin
                    check(1'b0, "R8 unexpected write", int'(wr_addr_o), -1);
                end
                widx++;
            end
            if (done_o) begin
                check(last_wr && widx == nwords, "R9 done timing", widx, nwords);
            end
            last_wr = wr_en_o;
        end
    end

    always @(posedge clk) begin
        total_cyc++;
        if (total_cyc > 150000) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", total_cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic build_exp(input int len, input int seed);
        int p;
        p = (len < 60) ? 60 : len;
        exp_w[0] = 16'h0000;
        exp_w[1] = 16'(p + 6);
        for (int k = 0; k < p / 2; k++) begin
            logic [7:0] a, b;
            a = (2 * k < len) ? pat(2 * k, seed) : 8'h00;
            b = (2 * k + 1 < len) ? pat(2 * k + 1, seed) : 8'h00;
            exp_w[2 + k] = {b, a};
        end
        if (p % 2 == 1) exp_w[2 + p / 2] = 16'h2000 | {8'h00, pat(p - 1, seed)};
        else            exp_w[2 + p / 2] = 16'h0000;
        nwords = 3 + p / 2;
    endtask

    task automatic run_frame(input int len, input int gap, input int seed, input bit mid_start);
        int idx;
        bit fin;
        build_exp(len, seed);
        widx = 0;
        last_wr = 1'b0;
        err_seen = 1'b0;
        mon_en = 1'b1;
        idx = 0;
        fin = 1'b0;
        @(negedge clk);
        start_i = 1'b1;
        len_i = 12'(len);
        @(negedge clk);
        start_i = 1'b0;
        for (int cyc = 0; cyc < 9000; cyc++) begin
            case (gap)
                1: byte_valid_i = cyc[0];
                2: byte_valid_i = (cyc % 3 == 2);
                default: byte_valid_i = 1'b1;
            endcase
            byte_data_i = pat(idx, seed);
            if (mid_start && cyc == 5) begin
                start_i = 1'b1;
                len_i = 12'd3000;
            end else begin
                start_i = 1'b0;
            end
            #1;
            if (byte_valid_i && byte_ready_o) idx++;
            if (done_o) begin
                fin = 1'b1;
                break;
            end
            @(negedge clk);
        end
        byte_valid_i = 1'b0;
        start_i = 1'b0;
        check(fin, "R9 frame completes", int'(fin), 1);
        check(idx == len, "R5 bytes taken", idx, len);
        check(widx == nwords, "R4 word count", widx, nwords);
        check(!err_seen, "R10 no error", int'(err_seen), 0);
        @(negedge clk);
        check(!done_o, "R9 done one cycle", int'(done_o), 0);
        mon_en = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        check(!wr_en_o && !done_o && !err_o && !byte_ready_o, "R1 in reset",
              int'({wr_en_o, done_o, err_o, byte_ready_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_en_o && !done_o && !err_o && !byte_ready_o, "R1 after reset",
              int'({wr_en_o, done_o, err_o, byte_ready_o}), 0);

        // table walk: R2..R7, R11
        for (int v = 0; v < NV; v++) begin
            run_frame(int'(VECS[v][13:2]), int'(VECS[v][1:0]), v * 17, 1'b0);
        end

        // R10: start strobe during an active frame
        run_frame(80, 1, 5, 1'b1);

        // R8: refusal at and beyond the limit
        for (int t = 0; t < 2; t++) begin
            nwords = 0;
            widx = 0;
            mon_en = 1'b1;
            @(negedge clk);
            start_i = 1'b1;
            len_i = (t == 0) ? 12'd2043 : 12'd4095;
            byte_valid_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(err_o, "R8 error pulse", int'(err_o), 1);
            check(!byte_ready_o, "R8 no byte taken", int'(byte_ready_o), 0);
            @(negedge clk);
            check(!err_o, "R8 single pulse", int'(err_o), 0);
            for (int c = 0; c < 10; c++) begin
                check(!byte_ready_o && !wr_en_o, "R8 idle after refusal",
                      int'({byte_ready_o, wr_en_o}), 0);
                @(negedge clk);
            end
            byte_valid_i = 1'b0;
            check(widx == 0, "R8 nothing written", widx, 0);
            mon_en = 1'b0;
        end

        // framer still usable after refusal
        run_frame(3, 0, 99, 1'b0);

        // R1: reset mid-frame returns to quiet outputs
        @(negedge clk);
        start_i = 1'b1;
        len_i = 12'd100;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!wr_en_o && !done_o && !err_o && !byte_ready_o, "R1 reset mid-frame",
              int'({wr_en_o, done_o, err_o, byte_ready_o}), 0);
        rst_n = 1'b1;
        run_frame(62, 2, 7, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule